// File: doc/BRIEF.md
# Sixteen-Byte FIFO on Single-Address RAM

This block is a small first-in first-out buffer of sixteen 8-bit entries. Its storage is a small RAM with one address port. The RAM is written on the clock edge and read without a clock. A write pointer and a read pointer each count through the sixteen locations. A multiplexer in front of the RAM address selects one pointer or the other, depending on which access the control logic grants in that cycle.

The RAM address can serve only one access per cycle. When both requests arrive together and the buffer holds data, the read takes the cycle. In that cycle `wr_ready` drops, and the writer keeps its request and data asserted until the next cycle. The read data is captured into a register when a read is granted, so it appears on `rd_data` one clock later. A request that cannot be served is ignored: a write while full, or a read while empty. The FIFO uses a synchronous active-high reset.

Top module: `srfifo`

## Requirements
- R1: While `rst` is high at a clock edge, both pointers return to zero. After that edge `empty`=1, `full`=0 and `rd_data`=0.
- R2: Bytes leave through `rd_data` in the order in which their writes were accepted.
- R3: `empty` is 1 exactly when no entries are held. `full` is 1 exactly when 16 entries are held. The two flags are never high together.
- R4: A write request while `full`=1 is ignored. It stores nothing and overwrites no held entry.
- R5: A read request while `empty`=1 is ignored. `rd_data` keeps its value and `empty` stays 1.
- R6: When `rd_req` and `wr_req` are both high and `empty`=0, only the read is done. `wr_ready` is 0 in that cycle and the offered byte is not stored. The same byte, offered again in a later cycle with `wr_ready`=1, is stored.
- R7: `rd_data` takes the oldest held byte at the clock edge that grants a read (`rd_req`=1 and `empty`=0). At every other edge it holds its value.
- R8: `wr_ready` equals (not `full`) and (not (`rd_req` and not `empty`)). A write is accepted exactly when `wr_req` and `wr_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Request to store `wr_data` |
| wr_data | input | 8 | Byte to store |
| wr_ready | output | 1 | A write requested in this cycle is accepted |
| rd_req | input | 1 | Request to remove the oldest byte |
| rd_data | output | 8 | Registered byte from the last granted read |
| full | output | 1 | All 16 entries are held |
| empty | output | 1 | No entries are held |

## Verification
The hardest case to reach is a request that collides with a boundary. Examples are a write arriving while the FIFO is exactly full, and a read and a write arriving together one entry away from empty or from full. Reaching these needs a run of one-sided traffic followed by a precise request pattern. After the vector table, directed sequences fill the FIFO to full, push an extra distinctive byte, drain it completely and read once more while empty. Each sequence checks the byte order against a queue model. Collision steps with a held write follow. A long run of seeded random traffic then covers the remaining pointer-wrap combinations.

// File: rtl/srfifo_pkg.sv
package srfifo_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;
endpackage

// File: rtl/srfifo_ptr.sv
module srfifo_ptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [AW:0]   ptr
);
  localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (inc) ptr <= ptr + ONE;
  end

  // R4/R5: a pointer moves only on a granted access
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(ptr));
endmodule

// File: rtl/srfifo_ctrl.sv
module srfifo_ctrl
  import srfifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_req,
  input  logic        rd_req,
  input  logic [AW:0] wptr,
  input  logic [AW:0] rptr,
  output acc_e        acc,
  output logic        we,
  output logic        rd_fire,
  output logic        wr_ready,
  output logic        full,
  output logic        empty
);
  always_comb begin
    empty    = (wptr == rptr);
    full     = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    rd_fire  = rd_req && !empty;
    wr_ready = !full && !rd_fire;
    we       = wr_req && wr_ready;
    if (rd_fire)  acc = ACC_READ;
    else if (we)  acc = ACC_WRITE;
    else          acc = ACC_IDLE;
  end

  p_excl_flags_r3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: rtl/srfifo_mem.sv
module srfifo_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          sel_rd,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];
  logic [AW-1:0] addr;

  // one shared address: the read pointer wins when a read is granted
  assign addr  = sel_rd ? raddr : waddr;
  assign rdata = cells[addr];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  // R6: a write never uses the address while it is steered to the reader
  p_write_addr_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> !sel_rd);
endmodule

// File: rtl/srfifo.sv
module srfifo
  import srfifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  logic [AW:0]   wptr, rptr;
  logic          we, rd_fire;
  acc_e          acc;
  logic [DW-1:0] mem_q;

  srfifo_ptr #(.AW(AW)) u_wptr (.clk(clk), .rst(rst), .inc(we),      .ptr(wptr));
  srfifo_ptr #(.AW(AW)) u_rptr (.clk(clk), .rst(rst), .inc(rd_fire), .ptr(rptr));

  srfifo_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_req(wr_req), .rd_req(rd_req),
    .wptr(wptr), .rptr(rptr), .acc(acc), .we(we), .rd_fire(rd_fire),
    .wr_ready(wr_ready), .full(full), .empty(empty)
  );

  srfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .we(we), .sel_rd(acc == ACC_READ),
    .waddr(wptr[AW-1:0]), .raddr(rptr[AW-1:0]),
    .wdata(wr_data), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_fire) rd_data <= mem_q;
  end

  p_dout_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rd_data));
  p_full_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    full |-> !we);
  p_empty_no_read_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req) |=> $stable(rd_data));
  p_collide_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !empty) |-> !wr_ready);
  p_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (!full && !rd_req) |-> wr_ready);
endmodule

// File: tb/tb_srfifo.sv
module tb_srfifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req = 1'b0;
  logic       wr_ready, full, empty;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] q[$];
  logic [7:0] exp_dout = 8'h00;

  always #5 clk = ~clk;

  srfifo dut (.clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
              .wr_ready(wr_ready), .rd_req(rd_req), .rd_data(rd_data),
              .full(full), .empty(empty));

  // {wr, rd, data}
  localparam logic [9:0] VEC [0:23] = '{
    {2'b10, 8'h11}, {2'b10, 8'h22}, {2'b10, 8'h33}, {2'b01, 8'h00},
    {2'b11, 8'h44}, {2'b10, 8'h44}, {2'b01, 8'h00}, {2'b01, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'h55}, {2'b10, 8'h55},
    {2'b00, 8'h00}, {2'b10, 8'h66}, {2'b11, 8'h77}, {2'b10, 8'h77},
    {2'b01, 8'h00}, {2'b10, 8'h88}, {2'b01, 8'h00}, {2'b01, 8'h00},
    {2'b01, 8'h00}, {2'b10, 8'h99}, {2'b11, 8'hAA}, {2'b01, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called just after a negedge: drive, check flags, clock, check rd_data
  task automatic step(input bit w, input bit r, input logic [7:0] d);
    bit rd_ok, wr_ok;
    string tag;
    wr_req = w; rd_req = r; wr_data = d;
    #1;
    rd_ok = r && (q.size() > 0);
    wr_ok = (q.size() < 16) && !rd_ok;
    chk("R3 empty", {7'd0, empty}, {7'd0, q.size() == 0});
    chk("R3 full",  {7'd0, full},  {7'd0, q.size() == 16});
    if (r && q.size() > 0)      chk("R6 wr_ready", {7'd0, wr_ready}, {7'd0, wr_ok});
    else if (q.size() == 16)    chk("R8 wr_ready", {7'd0, wr_ready}, {7'd0, wr_ok});
    else                        chk("R8 wr_ready", {7'd0, wr_ready}, {7'd0, wr_ok});
    if (rd_ok) exp_dout = q.pop_front();
    if (w && wr_ok) q.push_back(d);
    if (rd_ok) tag = "R2 rd_data";
    else if (r) tag = "R5 rd_data";
    else tag = "R7 rd_data";
    @(negedge clk);
    chk(tag, rd_data, exp_dout);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", {7'd0, empty}, 8'd1);
    chk("R1 full", {7'd0, full}, 8'd0);
    chk("R1 rd_data", rd_data, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < 24; i++) step(VEC[i][9], VEC[i][8], VEC[i][7:0]);
    while (q.size() > 0) step(1'b0, 1'b1, 8'h00);

    // R3/R4: fill to full, offer a distinctive byte, drain completely
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 8'hC0 + 8'(i));
    chk("R3 full after 16", {7'd0, full}, 8'd1);
    step(1'b1, 1'b0, 8'hEE);
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b1, 8'h00);
      chk("R4 no overwrite", rd_data, 8'hC0 + 8'(i));
    end
    chk("R3 empty after drain", {7'd0, empty}, 8'd1);
    // R5: read while empty
    step(1'b0, 1'b1, 8'h00);
    chk("R5 hold", rd_data, 8'hCF);
    // R6: collision with a held write, near full
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 8'(i));
    step(1'b1, 1'b1, 8'h5A);
    step(1'b1, 1'b0, 8'h5A);
    step(1'b1, 1'b0, 8'h5B);
    chk("R3 full after collide", {7'd0, full}, 8'd1);
    while (q.size() > 0) step(1'b0, 1'b1, 8'h00);

    for (int i = 0; i < 4000; i++)
      step(1'($urandom % 2), 1'(($urandom % 3) == 0 ? 0 : 1) & 1'($urandom % 2), 8'($urandom));
    for (int i = 0; i < 2000; i++)
      step(1'(($urandom % 4) != 0), 1'(($urandom % 4) == 0), 8'($urandom));
    for (int i = 0; i < 2000; i++)
      step(1'(($urandom % 4) == 0), 1'(($urandom % 4) != 0), 8'($urandom));

    // R1: reset mid-stream
    step(1'b1, 1'b0, 8'h12);
    rst = 1'b1; wr_req = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    q.delete(); exp_dout = 8'h00;
    chk("R1 empty again", {7'd0, empty}, 8'd1);
    chk("R1 rd_data again", rd_data, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule